// File: doc/BRIEF.md
# Edge boundary mask generator

This block turns a pair of byte addresses into a per-element write-enable mask for the partial first or last 8-byte word of a span. The first address marks where the span begins inside its word, and its offset selects the left-edge mask. The second address marks where the span ends, and its offset selects the right-edge mask. When both addresses fall in the same 8-byte block, the two masks are combined with AND. Otherwise only the left-edge mask is used. Element size can be 8, 16 or 32 bits, which gives 8, 4 or 2 mask lanes. Lane order follows the selected endianness.

When requested, the block also reports the negative, zero, overflow and carry flags of the first address minus the second. It gives them at both 64-bit and 32-bit width. A narrow addressing mode cuts both addresses to 32 bits for mask selection and for the block comparison. The flags always use the full inputs.

A caller pulses `req_i` with the operands. The results appear, registered, one clock later together with `valid_o`.

Top module: `edge_mask_gen`

## Requirements
- R1: `valid_o` is high in exactly the cycle after each cycle in which `req_i` is high. The mask, the error and the flags-valid outputs of a request appear in that same cycle, and `mask_o` holds its value while no request arrives.
- R2: With `elem_size_i`=0 (8-bit) and `little_i`=0, lane k is byte k of the block. Lane k drives `mask_o[7-k]`. The left mask enables lanes k >= a[2:0], and the right mask enables lanes k <= b[2:0].
- R3: With `elem_size_i`=0 and `little_i`=1, lane k drives `mask_o[k]`. The left mask and right mask are selected as in R2.
- R4: With `elem_size_i`=1 (16-bit), there are 4 lanes indexed by address bits [2:1]. Lane k drives bit 3-k in big-endian order and bit k in little-endian order. `mask_o[7:4]` is 0.
- R5: With `elem_size_i`=2 (32-bit), there are 2 lanes indexed by address bit [2]. Lane k drives bit 1-k in big-endian order and bit k in little-endian order. `mask_o[7:2]` is 0.
- R6: The result is left AND right only when the two addresses agree above bit 2. Otherwise it is the left mask alone.
- R7: With `narrow_i`=1, address bits [63:32] are treated as zero for both mask selection and the block comparison.
- R8: With `flags_en_i`=1, `flags_full_o` and `flags_narrow_o` are updated to {N,Z,V,C} (bit 3 down to bit 0) of a-b at 64 and at 32 bits. Both use the untruncated addresses. N is the sign of the difference and Z is set when the difference is zero. V is set on signed overflow. C is set when a < b unsigned.
- R9: A request with `flags_en_i`=0 leaves both flag outputs unchanged. `flags_valid_o` is high only in the result cycle of a request made with `flags_en_i`=1.
- R10: `elem_size_i`=3 is illegal. Its result has `mask_o`=0 and `size_err_o`=1. `size_err_o` is 0 in the result of every legal request.
- R11: After reset, `valid_o`, `flags_valid_o`, `size_err_o`, `mask_o` and both flag outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Operands valid this cycle |
| addr_a_i | input | 64 | Start address (left edge) |
| addr_b_i | input | 64 | End address (right edge) |
| elem_size_i | input | 2 | 0: 8-bit, 1: 16-bit, 2: 32-bit, 3: illegal |
| little_i | input | 1 | 1 selects little-endian lane order |
| flags_en_i | input | 1 | Also compute subtract flags |
| narrow_i | input | 1 | 32-bit addressing for mask and block compare |
| valid_o | output | 1 | Registered result valid |
| mask_o | output | 8 | Lane enable mask, zero-extended |
| size_err_o | output | 1 | Illegal element size in this result |
| flags_valid_o | output | 1 | Flags were updated with this result |
| flags_full_o | output | 4 | {N,Z,V,C} of a-b at 64 bits |
| flags_narrow_o | output | 4 | {N,Z,V,C} of a-b at 32 bits |

## Verification
The bench sweeps every pair of offsets for each element size and each endianness. It does this both inside one block and across blocks. A swapped lane order or an off-by-one in a table would show up as a mirrored mask or a shifted mask. Narrow-mode cases use addresses whose upper halves differ while their low halves share a block. A design that compared the full addresses would drop the right-edge AND in these cases.

Flag cases include a borrow, equal operands and signed overflow at both widths. A design that took carry as the adder carry-out, rather than as the borrow, would show C inverted. Requests made without flags, and with the illegal size, check that the flags hold and that a zero mask comes with the error bit.

// File: rtl/edge_mask_pkg.sv
package edge_mask_pkg;
  typedef enum logic [1:0] {
    ESZ_8   = 2'd0,
    ESZ_16  = 2'd1,
    ESZ_32  = 2'd2,
    ESZ_BAD = 2'd3
  } esize_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } nzvc_t;
endpackage

// File: rtl/edge_lane_mask.sv
module edge_lane_mask #(
  parameter int LANES = 8,
  localparam int OW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [OW-1:0]    off_a_i,
  input  logic [OW-1:0]    off_b_i,
  input  logic             little_i,
  input  logic             same_blk_i,
  output logic [LANES-1:0] mask_o
);
  localparam logic [LANES-1:0] ONES = '1;

  logic [LANES-1:0] left_m, right_m;
  logic [OW:0]      rsh;

  // right edge keeps lanes 0..off_b, i.e. drop LANES-1-off_b lanes
  assign rsh = (OW+1)'(LANES - 1) - {1'b0, off_b_i};

  always_comb begin
    if (little_i) begin
      left_m  = ONES << off_a_i;
      right_m = ONES >> rsh;
    end else begin
      left_m  = ONES >> off_a_i;
      right_m = ONES << rsh;
    end
  end

  assign mask_o = same_blk_i ? (left_m & right_m) : left_m;
endmodule

// File: rtl/edge_sub_flags.sv
module edge_sub_flags
  import edge_mask_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output nzvc_t        flags_o
);
  logic [W:0] diff;

  assign diff      = {1'b0, a_i} - {1'b0, b_i};
  assign flags_o.n = diff[W-1];
  assign flags_o.z = (diff[W-1:0] == '0);
  assign flags_o.v = (a_i[W-1] ^ b_i[W-1]) & (a_i[W-1] ^ diff[W-1]);
  assign flags_o.c = diff[W];  // borrow
endmodule

// File: rtl/edge_mask_gen.sv
module edge_mask_gen
  import edge_mask_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int NARROW_W  = 32,
  parameter int BLK_BYTES = 8,
  localparam int OFF_W    = $clog2(BLK_BYTES),
  localparam int NSIZES   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_a_i,
  input  logic [ADDR_W-1:0] addr_b_i,
  input  logic [1:0]        elem_size_i,
  input  logic              little_i,
  input  logic              flags_en_i,
  input  logic              narrow_i,
  output logic              valid_o,
  output logic [BLK_BYTES-1:0] mask_o,
  output logic              size_err_o,
  output logic              flags_valid_o,
  output logic [3:0]        flags_full_o,
  output logic [3:0]        flags_narrow_o
);
  logic [ADDR_W-1:0] a_eff, b_eff;
  logic              same_blk;
  logic [NSIZES-1:0][BLK_BYTES-1:0] cand;
  logic [BLK_BYTES-1:0] mask_d;
  logic              bad_size;
  nzvc_t             fl_full, fl_narrow;

  assign a_eff = narrow_i ? {{(ADDR_W-NARROW_W){1'b0}}, addr_a_i[NARROW_W-1:0]} : addr_a_i;
  assign b_eff = narrow_i ? {{(ADDR_W-NARROW_W){1'b0}}, addr_b_i[NARROW_W-1:0]} : addr_b_i;
  assign same_blk = (a_eff[ADDR_W-1:OFF_W] == b_eff[ADDR_W-1:OFF_W]);

  for (genvar g = 0; g < NSIZES; g++) begin : g_size
    localparam int LN = BLK_BYTES >> g;
    logic [LN-1:0] lane_m;

    edge_lane_mask #(.LANES(LN)) u_lane (
      .off_a_i   (a_eff[OFF_W-1:g]),
      .off_b_i   (b_eff[OFF_W-1:g]),
      .little_i  (little_i),
      .same_blk_i(same_blk),
      .mask_o    (lane_m)
    );
    assign cand[g] = BLK_BYTES'(lane_m);
  end

  assign bad_size = (esize_e'(elem_size_i) == ESZ_BAD);

  always_comb begin
    unique case (esize_e'(elem_size_i))
      ESZ_8:   mask_d = cand[0];
      ESZ_16:  mask_d = cand[1];
      ESZ_32:  mask_d = cand[2];
      default: mask_d = '0;
    endcase
  end

  edge_sub_flags #(.W(ADDR_W)) u_flags_full (
    .a_i(addr_a_i), .b_i(addr_b_i), .flags_o(fl_full)
  );
  edge_sub_flags #(.W(NARROW_W)) u_flags_narrow (
    .a_i(addr_a_i[NARROW_W-1:0]), .b_i(addr_b_i[NARROW_W-1:0]), .flags_o(fl_narrow)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o        <= 1'b0;
      mask_o         <= '0;
      size_err_o     <= 1'b0;
      flags_valid_o  <= 1'b0;
      flags_full_o   <= '0;
      flags_narrow_o <= '0;
    end else begin
      valid_o       <= req_i;
      size_err_o    <= req_i & bad_size;
      flags_valid_o <= req_i & flags_en_i;
      if (req_i) mask_o <= mask_d;
      if (req_i && flags_en_i) begin
        flags_full_o   <= fl_full;
        flags_narrow_o <= fl_narrow;
      end
    end
  end
endmodule

// File: rtl/edge_mask_gen_chk.sv
module edge_mask_gen_chk #(
  parameter int ADDR_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic [ADDR_W-1:0] addr_a_i,
  input logic [ADDR_W-1:0] addr_b_i,
  input logic [1:0]        elem_size_i,
  input logic              little_i,
  input logic              flags_en_i,
  input logic              narrow_i,
  input logic              valid_o,
  input logic [7:0]        mask_o,
  input logic              size_err_o,
  input logic              flags_valid_o,
  input logic [3:0]        flags_full_o,
  input logic [3:0]        flags_narrow_o
);
  a_r1_valid_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> valid_o);
  a_r1_no_spurious_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !valid_o);
  a_r1_mask_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> $stable(mask_o));
  a_r4_zero_ext16: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && elem_size_i == 2'd1 |=> mask_o[7:4] == 4'h0);
  a_r5_zero_ext32: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && elem_size_i == 2'd2 |=> mask_o[7:2] == 6'h0);
  a_r8_equal_operands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && flags_en_i && addr_a_i == addr_b_i |=>
      flags_full_o == 4'b0100 && flags_narrow_o == 4'b0100);
  a_r9_flags_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && flags_en_i) |=> $stable(flags_full_o) && $stable(flags_narrow_o));
  a_r9_fv_with_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_valid_o |-> valid_o);
  a_r10_bad_size: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && elem_size_i == 2'd3 |=> size_err_o && mask_o == 8'h00);
  a_r10_no_err_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && elem_size_i != 2'd3 |=> !size_err_o);
endmodule

bind edge_mask_gen edge_mask_gen_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/edge_mask_gen_tb.sv
module edge_mask_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [63:0] a = '0, b = '0;
  logic [1:0]  sz = '0;
  logic        le = 1'b0, fen = 1'b0, nar = 1'b0;

  logic        valid, serr, fv;
  logic [7:0]  mask;
  logic [3:0]  ff, fn;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  string phase = "R11";

  always #10 clk = ~clk;

  edge_mask_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_a_i(a), .addr_b_i(b),
    .elem_size_i(sz), .little_i(le), .flags_en_i(fen), .narrow_i(nar),
    .valid_o(valid), .mask_o(mask), .size_err_o(serr), .flags_valid_o(fv),
    .flags_full_o(ff), .flags_narrow_o(fn)
  );

  // behavioural reference
  function automatic logic [7:0] ref_mask(logic [63:0] x, logic [63:0] y,
                                          logic [1:0] s, logic little, logic narrow);
    logic [7:0] m = '0;
    int n, ea, eb;
    bit same;
    if (s == 2'd3) return 8'h00;
    if (narrow) begin
      x = x & 64'hFFFF_FFFF;
      y = y & 64'hFFFF_FFFF;
    end
    n    = 8 >> s;
    ea   = int'(x[2:0]) >> s;
    eb   = int'(y[2:0]) >> s;
    same = ((x >> 3) == (y >> 3));
    for (int k = 0; k < n; k++) begin
      if (k >= ea && (!same || k <= eb)) m[little ? k : n - 1 - k] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [3:0] ref_flags64(logic [63:0] x, logic [63:0] y);
    logic [63:0] d = x - y;
    logic nn = d[63];
    logic lt = ($signed(x) < $signed(y));
    return {nn, d == 64'd0, nn ^ lt, x < y};
  endfunction

  function automatic logic [3:0] ref_flags32(logic [31:0] x, logic [31:0] y);
    logic [31:0] d = x - y;
    logic nn = d[31];
    logic lt = ($signed(x) < $signed(y));
    return {nn, d == 32'd0, nn ^ lt, x < y};
  endfunction

  logic       m_valid, m_err, m_fv;
  logic [7:0] m_mask;
  logic [3:0] m_ff, m_fn;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 0; m_err <= 0; m_fv <= 0; m_mask <= 0; m_ff <= 0; m_fn <= 0;
    end else begin
      m_valid <= req;
      m_err   <= req && sz == 2'd3;
      m_fv    <= req && fen;
      if (req) m_mask <= ref_mask(a, b, sz, le, nar);
      if (req && fen) begin
        m_ff <= ref_flags64(a, b);
        m_fn <= ref_flags32(a[31:0], b[31:0]);
      end
    end
  end

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", phase, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk("valid", 64'(valid), 64'(m_valid));
      chk("mask", 64'(mask), 64'(m_mask));
      chk("size_err", 64'(serr), 64'(m_err));
      chk("flags_valid", 64'(fv), 64'(m_fv));
      chk("flags_full", 64'(ff), 64'(m_ff));
      chk("flags_narrow", 64'(fn), 64'(m_fn));
    end
  end

  task automatic issue(logic [63:0] x, logic [63:0] y, logic [1:0] s,
                       logic little, logic f, logic narrow);
    @(negedge clk);
    req = 1'b1; a = x; b = y; sz = s; le = little; fen = f; nar = narrow;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req = 1'b0;
    end
  endtask

  initial begin
    logic [63:0] base;
    repeat (3) @(negedge clk);
    // R11: reset values compared by the monitor while held in reset
    rst_n = 1'b1;
    idle(2);

    // R2: 8-bit big-endian, all offset pairs in one block
    phase = "R2";
    base = 64'h1234_5678_9ABC_DE00;
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++) issue(base + 64'(i), base + 64'(j), 2'd0, 1'b0, 1'b0, 1'b0);
    // R3: little-endian
    phase = "R3";
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++) issue(base + 64'(i), base + 64'(j), 2'd0, 1'b1, 1'b0, 1'b0);
    // R4 and R5: wider elements, both orders
    phase = "R4";
    for (int e = 0; e < 2; e++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++) issue(base + 64'(i), base + 64'(j), 2'd1, e[0], 1'b0, 1'b0);
    phase = "R5";
    for (int e = 0; e < 2; e++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++) issue(base + 64'(i), base + 64'(j), 2'd2, e[0], 1'b0, 1'b0);
    // R6: different blocks, left mask only
    phase = "R6";
    for (int s = 0; s < 3; s++)
      for (int i = 0; i < 8; i++) begin
        issue(base + 64'(i), base + 64'h8 + 64'(7 - i), 2'(s), 1'b0, 1'b0, 1'b0);
        issue(base + 64'h40 + 64'(i), base + 64'(i), 2'(s), 1'b1, 1'b0, 1'b0);
      end
    // R7: upper halves differ, low halves share a block
    phase = "R7";
    for (int i = 0; i < 8; i++) begin
      issue(64'hAAAA_0000_0000_1000 + 64'(i), 64'h5555_0000_0000_1000 + 64'(7 - i), 2'd0, 1'b0, 1'b0, 1'b1);
      issue(64'hAAAA_0000_0000_1000 + 64'(i), 64'h5555_0000_0000_1000 + 64'(7 - i), 2'd0, 1'b0, 1'b0, 1'b0);
    end
    // R8: flag corners
    phase = "R8";
    issue(64'd0, 64'd1, 2'd0, 1'b0, 1'b1, 1'b0);
    issue(64'd5, 64'd5, 2'd0, 1'b0, 1'b1, 1'b0);
    issue(64'h8000_0000_0000_0000, 64'd1, 2'd1, 1'b0, 1'b1, 1'b0);
    issue(64'h7FFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 2'd2, 1'b1, 1'b1, 1'b1);
    issue(64'h0000_0001_8000_0000, 64'h0000_0000_0000_0001, 2'd0, 1'b0, 1'b1, 1'b1);
    issue(64'h1_0000_0000, 64'h0, 2'd0, 1'b0, 1'b1, 1'b0);
    // R9: no-flag requests keep flags
    phase = "R9";
    issue(64'd3, 64'd9, 2'd0, 1'b0, 1'b0, 1'b0);
    idle(1);
    issue(64'd9, 64'd3, 2'd0, 1'b0, 1'b1, 1'b0);
    issue(64'd0, 64'hFFFF, 2'd1, 1'b1, 1'b0, 1'b0);
    idle(2);
    // R10: illegal size
    phase = "R10";
    issue(base + 64'd2, base + 64'd6, 2'd3, 1'b0, 1'b0, 1'b0);
    issue(base + 64'd1, base + 64'd2, 2'd0, 1'b1, 1'b0, 1'b0);
    issue(base, base + 64'd7, 2'd3, 1'b1, 1'b1, 1'b0);
    idle(1);
    // R1: back-to-back and gapped random traffic
    phase = "R1";
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 3) == 0) idle(1);
      else issue({$urandom, $urandom}, ($urandom_range(0, 1) != 0) ? {$urandom, $urandom}
                 : {$urandom, $urandom} ^ 64'h7,
                 2'($urandom_range(0, 3)), 1'($urandom), 1'($urandom), 1'($urandom));
    end
    idle(3);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog R1 act=hung exp=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule